// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit control register that places the memory-mapped PCIe configuration window in the CPU address map. It turns that register into a live window and decodes every CPU memory address presented to it. Software updates the register through a byte-lane write port. An enable bit and a two-bit size code in the register select a window of 256 MB, 128 MB or 64 MB. The size code also decides which of the register's upper bits make up the window base. One size code is reserved, and that code shuts the window off whatever the enable bit holds.

Each lookup returns a registered response one clock later. The response says whether the address falls inside the window. On a hit it also gives the bus, device, function and register offset that the address selects. Miss responses carry zero in all four fields. A downstream configuration engine uses these to build the configuration transaction. A lookup always uses the register value that was in place in the cycle the request was presented. A write therefore affects only lookups issued in later cycles.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 0x0000_0000_B000_0000 (window disabled, size code 00, base 0xB000_0000) and no response is valid.
- R2: A write changes only the byte lanes whose enable bit is set. Byte lane b covers bits 8b+7 down to 8b.
- R3: Only bit 0 (enable), bits 2:1 (size code) and bits 35:26 (base) are stored. Every other bit reads back as zero.
- R4: While bit 0 is clear, no address hits.
- R5: Size code 00 selects a 256 MB window. Its base is register bits 35:28, and register bits 27:26 are ignored for decoding.
- R6: Size code 01 selects a 128 MB window whose base is register bits 35:27. Register bit 26 is ignored.
- R7: Size code 10 selects a 64 MB window whose base is register bits 35:26.
- R8: Size code 11 gives a zero-size window that never hits, even with bit 0 set.
- R9: A hit means base <= address < base + size. Addresses at base + size, below base, or with any bit above 35 set do not hit.
- R10: On a hit the response carries register offset = address[11:0], function = address[14:12] and device = address[19:15]. It also carries bus = address[27:20], limited to its low 7 bits for 128 MB and its low 6 bits for 64 MB. On a miss all four fields are zero.
- R11: A response is valid exactly one cycle after a request. It uses the register value from the request cycle, so a write issued in the same cycle as a lookup does not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Per-byte write enables |
| wr_data | input | 64 | Register write data |
| cfg_value | output | 64 | Current register contents |
| req_valid | input | 1 | Address lookup request |
| req_addr | input | ADDR_W (40) | CPU memory address to decode |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Address lies inside the window |
| rsp_bus | output | 8 | Bus number on a hit |
| rsp_dev | output | 5 | Device number on a hit |
| rsp_fn | output | 3 | Function number on a hit |
| rsp_reg | output | 12 | Register offset on a hit |

## Verification
Some properties are checked on every cycle. These are the one-cycle response timing, the zero read-back of undefined bits and the hold of byte lanes that were not enabled. The absence of hits while disabled or under the reserved code is also checked every cycle, as are the truncated bus field, zero fields on a miss, and the register offset tracking the request address. Window placement needs the bench's scenarios. These cover the inclusive lower and exclusive upper edges for each size, and the masking of the low base bits that each size ignores. They also cover addresses above the decoded range and the ordering of a write against a lookup in the same cycle.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   localparam int EN_BIT   = 0;
   localparam int SZ_LSB   = 1;
   localparam int LSB_256M = 28;
   localparam int LSB_128M = 27;
   localparam int LSB_64M  = 26;

   typedef enum logic [1:0] {
      WIN_256M = 2'b00,
      WIN_128M = 2'b01,
      WIN_64M  = 2'b10,
      WIN_NONE = 2'b11
   } win_size_e;

   typedef struct packed {
      logic        hit;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] off;
   } cfg_loc_t;

   // Bits that hold state: enable, size code and base bits base_hi..26.
   function automatic logic [63:0] stored_bits(input int base_hi);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if ((i >= LSB_64M && i <= base_hi) || i <= SZ_LSB + 1) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg
   import cfgwin_pkg::*;
#(
   parameter int          REG_W     = 64,
   parameter int          BASE_HI   = 35,
   parameter logic [63:0] RST_VALUE = 64'h0000_0000_B000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W/8-1:0] wr_be,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   q
);
   localparam int NLANES = REG_W / 8;
   localparam logic [REG_W-1:0] KEEP    = REG_W'(stored_bits(BASE_HI));
   localparam logic [REG_W-1:0] RST_VAL = REG_W'(RST_VALUE) & KEEP;

   if (REG_W % 8 != 0 || REG_W > 64 || BASE_HI >= REG_W) begin : g_bad_cfg
      $error("cfgwin_reg: REG_W must be a multiple of 8, at most 64, and above BASE_HI");
   end

   logic [7:0] lane_q [NLANES];

   for (genvar b = 0; b < NLANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[b] <= RST_VAL[8*b +: 8];
         end else if (wr_en && wr_be[b]) begin
            lane_q[b] <= wr_data[8*b +: 8] & KEEP[8*b +: 8];
         end
      end
      assign q[8*b +: 8] = lane_q[b];
   end

endmodule

// File: rtl/cfgwin_size.sv
module cfgwin_size
   import cfgwin_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int BASE_HI = 35
) (
   input  logic [ADDR_W-1:0] cfg_lo,
   output logic              win_on,
   output win_size_e         win_code,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W:0]   win_span
);
   if (BASE_HI < LSB_256M || BASE_HI >= ADDR_W) begin : g_bad_cfg
      $error("cfgwin_size: BASE_HI must lie between 28 and ADDR_W-1");
   end

   int                lo_bit;
   logic [ADDR_W-1:0] keep;

   always_comb begin
      win_code = win_size_e'(cfg_lo[SZ_LSB +: 2]);
      unique case (win_code)
         WIN_256M: lo_bit = LSB_256M;
         WIN_128M: lo_bit = LSB_128M;
         WIN_64M:  lo_bit = LSB_64M;
         default:  lo_bit = LSB_256M;
      endcase
      for (int i = 0; i < ADDR_W; i++) begin
         keep[i] = (i >= lo_bit) && (i <= BASE_HI);
      end
      win_base = cfg_lo & keep;
      win_span = (win_code == WIN_NONE) ? '0 : ((ADDR_W + 1)'(1) << lo_bit);
      win_on   = cfg_lo[EN_BIT] && (win_span != '0);
   end

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
   import cfgwin_pkg::*;
#(
   parameter int ADDR_W   = 40,
   parameter bit RSP_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              win_on,
   input  win_size_e         win_code,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W:0]   win_span,
   output logic              rsp_valid,
   output cfg_loc_t          rsp_loc
);
   logic [ADDR_W:0] addr_x, base_x, limit_x;
   logic [7:0]      bus_keep;
   logic            in_range;
   cfg_loc_t        loc_d;

   always_comb begin
      addr_x   = {1'b0, req_addr};
      base_x   = {1'b0, win_base};
      limit_x  = base_x + win_span;
      in_range = win_on && (addr_x >= base_x) && (addr_x < limit_x);
      unique case (win_code)
         WIN_256M: bus_keep = 8'hFF;
         WIN_128M: bus_keep = 8'h7F;
         WIN_64M:  bus_keep = 8'h3F;
         default:  bus_keep = 8'h00;
      endcase
      loc_d = '0;
      if (in_range) begin
         loc_d.hit = 1'b1;
         loc_d.bus = req_addr[27:20] & bus_keep;
         loc_d.dev = req_addr[19:15];
         loc_d.fn  = req_addr[14:12];
         loc_d.off = req_addr[11:0];
      end
   end

   if (RSP_PIPE) begin : g_reg_rsp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_loc   <= '0;
         end else begin
            rsp_valid <= req_valid;
            rsp_loc   <= req_valid ? loc_d : '0;
         end
      end
   end else begin : g_comb_rsp
      assign rsp_valid = req_valid;
      assign rsp_loc   = req_valid ? loc_d : '0;
   end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
   import cfgwin_pkg::*;
#(
   parameter int          ADDR_W    = 40,
   parameter int          BASE_HI   = 35,
   parameter logic [63:0] RST_VALUE = 64'h0000_0000_B000_0000,
   parameter bit          RSP_PIPE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_be,
   input  logic [63:0]       wr_data,
   output logic [63:0]       cfg_value,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [7:0]        rsp_bus,
   output logic [4:0]        rsp_dev,
   output logic [2:0]        rsp_fn,
   output logic [11:0]       rsp_reg
);
   localparam int REG_W = 64;

   if (ADDR_W > REG_W) begin : g_bad_cfg
      $error("cfgwin_decoder: ADDR_W must not exceed the register width");
   end

   logic [REG_W-1:0]  cfg_q;
   logic              win_on;
   win_size_e         win_code;
   logic [ADDR_W-1:0] win_base;
   logic [ADDR_W:0]   win_span;
   cfg_loc_t          loc;

   cfgwin_reg #(
      .REG_W     (REG_W),
      .BASE_HI   (BASE_HI),
      .RST_VALUE (RST_VALUE)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .q       (cfg_q)
   );

   cfgwin_size #(
      .ADDR_W  (ADDR_W),
      .BASE_HI (BASE_HI)
   ) u_size (
      .cfg_lo   (cfg_q[ADDR_W-1:0]),
      .win_on   (win_on),
      .win_code (win_code),
      .win_base (win_base),
      .win_span (win_span)
   );

   cfgwin_match #(
      .ADDR_W   (ADDR_W),
      .RSP_PIPE (RSP_PIPE)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .win_on    (win_on),
      .win_code  (win_code),
      .win_base  (win_base),
      .win_span  (win_span),
      .rsp_valid (rsp_valid),
      .rsp_loc   (loc)
   );

   assign cfg_value = cfg_q;
   assign rsp_hit   = loc.hit;
   assign rsp_bus   = loc.bus;
   assign rsp_dev   = loc.dev;
   assign rsp_fn    = loc.fn;
   assign rsp_reg   = loc.off;

endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk
   import cfgwin_pkg::*;
#(
   parameter int ADDR_W   = 40,
   parameter int BASE_HI  = 35,
   parameter bit RSP_PIPE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_be,
   input logic [63:0]       cfg_value,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [7:0]        rsp_bus,
   input logic [4:0]        rsp_dev,
   input logic [2:0]        rsp_fn,
   input logic [11:0]       rsp_reg
);
   localparam logic [63:0] STORED = stored_bits(BASE_HI);

   // R3
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_value & ~STORED) == 64'h0);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_value));

   for (genvar b = 0; b < 8; b++) begin : g_lane_chk
      // R2
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_be[b]) |=> $stable(cfg_value[8*b +: 8]));
   end

   // R10
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_bus == 8'h0 && rsp_dev == 5'h0 &&
                                   rsp_fn == 3'h0 && rsp_reg == 12'h0));

   if (RSP_PIPE) begin : g_pipe_chk
      // R11
      rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);

      // R11
      no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid);

      // R4
      disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !cfg_value[0]) |=> !rsp_hit);

      // R8
      reserved_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && cfg_value[2:1] == 2'b11) |=> !rsp_hit);

      // R6
      bus_trunc128_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && cfg_value[2:1] == 2'b01) |=> !rsp_bus[7]);

      // R7
      bus_trunc64_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && cfg_value[2:1] == 2'b10) |=> rsp_bus[7:6] == 2'b00);

      // R10
      offset_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && cfg_value[0]) |=> (!rsp_hit || rsp_reg == $past(req_addr[11:0])));
   end

endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
   .ADDR_W   (ADDR_W),
   .BASE_HI  (BASE_HI),
   .RSP_PIPE (RSP_PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_be     (wr_be),
   .cfg_value (cfg_value),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_bus   (rsp_bus),
   .rsp_dev   (rsp_dev),
   .rsp_fn    (rsp_fn),
   .rsp_reg   (rsp_reg)
);

// File: tb/cfgwin_decoder_test.sv
`timescale 1ns/1ps
module cfgwin_decoder_test;

   localparam int          AW       = 40;
   localparam logic [63:0] RST_EXP  = 64'h0000_0000_B000_0000;
   localparam logic [63:0] KEEP_EXP = 64'h0000_000F_FC00_0007;

   typedef struct packed {
      logic        hit;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] off;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_be = '0;
   logic [63:0]   wr_data = '0;
   logic [63:0]   cfg_value;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_hit;
   logic [7:0]    rsp_bus;
   logic [4:0]    rsp_dev;
   logic [2:0]    rsp_fn;
   logic [11:0]   rsp_reg;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [63:0] model = RST_EXP;
   exp_t  exp_q [$];
   string tag_q [$];

   always #2 clk = ~clk;

   cfgwin_decoder uut (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_be (wr_be), .wr_data (wr_data),
      .cfg_value (cfg_value),
      .req_valid (req_valid), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
      .rsp_bus (rsp_bus), .rsp_dev (rsp_dev), .rsp_fn (rsp_fn), .rsp_reg (rsp_reg)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic exp_t predict(input logic [63:0] m, input logic [AW-1:0] a);
      exp_t        e;
      int          lo;
      logic [63:0] span, base, ax;
      logic [7:0]  bmask;
      e = '0;
      case (m[2:1])
         2'b00:   begin lo = 28; span = 64'h1 << 28; bmask = 8'hFF; end
         2'b01:   begin lo = 27; span = 64'h1 << 27; bmask = 8'h7F; end
         2'b10:   begin lo = 26; span = 64'h1 << 26; bmask = 8'h3F; end
         default: begin lo = 28; span = 64'h0;       bmask = 8'h00; end
      endcase
      base = m & ((64'h1 << 36) - 1) & ~((64'h1 << lo) - 1);
      ax   = 64'(a);
      if (m[0] && span != 0 && ax >= base && ax < base + span) begin
         e.hit = 1'b1;
         e.bus = a[27:20] & bmask;
         e.dev = a[19:15];
         e.fn  = a[14:12];
         e.off = a[11:0];
      end
      return e;
   endfunction

   function automatic logic [63:0] apply(input logic [63:0] m, input logic [7:0] be, input logic [63:0] d);
      logic [63:0] r;
      r = m;
      for (int b = 0; b < 8; b++) begin
         if (be[b]) r[8*b +: 8] = d[8*b +: 8] & KEEP_EXP[8*b +: 8];
      end
      return r;
   endfunction

   task automatic do_write(input logic [7:0] be, input logic [63:0] d);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
      model = apply(model, be, d);
   endtask

   task automatic do_look(input logic [AW-1:0] a, input string tag);
      exp_q.push_back(predict(model, a));
      tag_q.push_back(tag);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_both(input logic [7:0] be, input logic [63:0] d, input logic [AW-1:0] a, input string tag);
      exp_q.push_back(predict(model, a));
      tag_q.push_back(tag);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0; req_valid = 1'b0;
      model = apply(model, be, d);
   endtask

   task automatic check_reg(input string tag);
      check(cfg_value == model, tag, cfg_value, model);
   endtask

   // Monitor: pops expected responses in order and compares.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 response without request", 64'(rsp_hit), 64'h0);
         end else begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {rsp_hit, rsp_bus, rsp_dev, rsp_fn, rsp_reg};
            check(a == e, t, 64'(a), 64'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset contents and idle response
      check(cfg_value == RST_EXP, "R1 reset value", cfg_value, RST_EXP);
      check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'h0);

      // R4: disabled window never hits
      do_look(40'h00_B000_0000, "R4 disabled at base");
      do_look(40'h00_B123_4567, "R4 disabled inside");

      // R5/R9/R10: 256 MB window at 0xB000_0000
      do_write(8'h01, 64'h1);
      check_reg("R5 enable write");
      do_look(40'h00_B000_0000, "R9 lower edge 256M");
      do_look(40'h00_BFFF_FFFF, "R9 last byte 256M");
      do_look(40'h00_C000_0000, "R9 upper edge 256M");
      do_look(40'h00_AFFF_FFFF, "R9 below base 256M");
      do_look(40'h00_B0A5_B123, "R10 fields 256M");
      do_look(40'h80_B000_0000, "R9 high address bit");

      // R5: bits 27:26 ignored for 256 MB
      do_write(8'h08, 64'h0000_0000_BC00_0000);
      check_reg("R5 base with low bits");
      do_look(40'h00_B000_0000, "R5 low base bits ignored");

      // R11: write and lookup in the same cycle
      do_both(8'h01, 64'h0, 40'h00_B000_1000, "R11 lookup before write");
      do_look(40'h00_B000_1000, "R11 lookup after write");

      // R3: undefined bits read as zero
      do_write(8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
      check(cfg_value == KEEP_EXP, "R3 undefined bits zero", cfg_value, KEEP_EXP);

      // R8: reserved size code with enable set
      do_look(40'h0F_FC00_0000, "R8 reserved code");
      do_look(40'h0F_FFFF_FFFF, "R8 reserved code top");

      // R2: only enabled lanes change
      do_write(8'hFF, 64'h0);
      do_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
      check(cfg_value == 64'h0000_0000_FC00_0000, "R2 single lane write", cfg_value, 64'hFC00_0000);
      do_write(8'h10, 64'h0000_0001_0000_0000);
      check_reg("R2 upper lane write");

      // R6: 128 MB, bit 26 ignored, bus truncated
      do_write(8'hFF, 64'h0000_0001_2C00_0003);
      check_reg("R6 128M write");
      do_look(40'h01_2800_0000, "R6 base bit 26 ignored");
      do_look(40'h01_2FF0_0000, "R6 bus truncated");
      do_look(40'h01_3000_0000, "R6 upper edge");
      do_look(40'h01_27FF_FFFF, "R6 below base");

      // R7: 64 MB window at 0xB400_0000
      do_write(8'hFF, 64'h0000_0000_B400_0005);
      check_reg("R7 64M write");
      do_look(40'h00_B400_0000, "R7 lower edge");
      do_look(40'h00_B7FF_FFFF, "R7 last byte bus truncated");
      do_look(40'h00_B800_0000, "R7 upper edge");
      do_look(40'h00_B3FF_FFFF, "R7 below base");
      do_look(40'h00_B5A7_9ABC, "R10 fields 64M");

      // R8: reserved code keeps window off after enable
      do_write(8'h01, 64'h7);
      do_look(40'h00_B400_0000, "R8 reserved after 64M");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R11 all responses returned", 64'(exp_q.size()), 64'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule